// File: doc/BRIEF.md
# Request-Block Ring Producer

This block owns the enqueue side of a command or transfer ring. The ring consists of 16-byte request blocks kept in a local memory of 2^LOG2+1 entries. The first 2^LOG2 entries hold data blocks. The last entry is a permanent link block whose pointer field sends the consumer back to entry 0. The memory itself sits outside the block, which drives only a single write port into it.

Each accepted request is formatted and written at the current producer index. The block stamps the request's cycle bit with the producer cycle state and places a saturated transfer-descriptor size into the status word. In the same cycle it raises a doorbell write. When the last data entry has been filled, the block spends one cycle rewriting the link block with the current cycle state, and then inverts that state.

A consumer-advance pulse frees one entry. Fill, space and full are reported at all times. One slot is always kept empty, so the usable capacity is 2^LOG2-1.

The enqueue side is a valid/ready stream. A request is taken on a cycle where both enq_valid and enq_ready are high. enq_ready drops only for the link-write cycle after reset and for the link-write cycle after each wrap, and the source must hold its request until ready returns. A request taken while the ring is full is consumed and discarded: enq_err pulses and nothing is written. All memory, doorbell and error outputs are registered and appear in the cycle after acceptance.

Top module: `trb_ring_producer`

## Requirements
- R1: After reset the counters are 0 and the cycle state is 1. In the first cycle out of reset enq_ready is 0, and the link block is written at index 2^LOG2. The link block carries LINK_PTR in bits [63:0], type 6 in control bits [111:106] (control word bits 15:10), the toggle-cycle flag set (bit 97, control bit 1) and its cycle bit clear (bit 96, control bit 0).
- R2: fill equals producer minus consumer count modulo 2^CNT_W. space equals 2^LOG2-1 minus fill. full is high exactly when fill equals 2^LOG2-1, and fill never exceeds that value.
- R3: An accepted, non-full request is written one cycle later at index prod mod 2^LOG2. The parameter goes to bits [63:0], status to [95:64] and control to [127:96]. Control bit 0 is replaced by the cycle state, and the other control bits (chain 4, interrupt-on-completion 5, immediate 6, type 15:10) pass through unchanged.
- R4: Status bits 21:17 of a written data block hold min(enq_remain, 15). All other status bits are kept.
- R5: Each data write comes with db_we for one cycle and db_value = enq_target | (enq_stream << 16).
- R6: A request taken while full gives a one-cycle enq_err, with no memory write, no doorbell write and no counter change.
- R7: A cons_adv pulse increments the consumer count when fill is non-zero. When the ring is empty it is ignored.
- R8: An enqueue and a cons_adv in the same cycle both take effect. Fullness is judged on the count before that cycle.
- R9: The cycle after the write to index 2^LOG2-1 has enq_ready low. At the end of that cycle the link block is written with the current cycle state, and the state then inverts, so that later data blocks carry the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Request present |
| enq_ready | output | 1 | Request can be taken |
| enq_param | input | 64 | Parameter field |
| enq_status | input | 32 | Status field |
| enq_ctrl | input | 32 | Control field (flags byte, type byte) |
| enq_remain | input | REM_W | Remaining packet count for the size field |
| enq_target | input | 16 | Doorbell target |
| enq_stream | input | 16 | Doorbell stream ID |
| enq_err | output | 1 | Request rejected, ring full |
| cons_adv | input | 1 | Consumer freed one entry |
| mem_we | output | 1 | Ring memory write enable |
| mem_addr | output | LOG2+1 | Ring memory index |
| mem_data | output | 128 | Ring memory write data |
| fill | output | CNT_W | Occupied entries |
| space | output | CNT_W | Free usable entries |
| full | output | 1 | No usable entry free |
| db_we | output | 1 | Doorbell write strobe |
| db_value | output | 32 | Doorbell write value |

## Verification
Enqueue and consumer advance can occur in the same cycle. The bench applies both together in two situations. With the ring full, the request must be rejected while the count still drops by one. With the ring below full, the request must be written and the fill level must stay flat. A second collision is a request that writes the last data entry: the following link-write cycle must block the stream. The bench checks that ready is low there, that the link block carries the old cycle state, and that the next data block carries the inverted state.

// File: rtl/trb_ring_pkg.sv
package trb_ring_pkg;
  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] status;
    logic [63:0] param;
  } trb_t;

  localparam logic [5:0] TYPE_NORMAL = 6'd1;
  localparam logic [5:0] TYPE_LINK   = 6'd6;
  localparam logic [5:0] TYPE_NOP    = 6'd8;
  localparam int FLAG_CYCLE  = 0;
  localparam int FLAG_TOGGLE = 1;
  localparam int TYPE_LSB    = 10;
  localparam int TDSZ_LSB    = 17;
  localparam int TDSZ_W      = 5;

  typedef enum logic [1:0] {PH_INIT, PH_RUN, PH_LINK} phase_t;
endpackage

// File: rtl/trb_ring_ctr.sv
module trb_ring_ctr #(
  parameter int LOG2  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec_req,
  output logic [CNT_W-1:0] prod,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] space,
  output logic             full
);
  localparam logic [CNT_W-1:0] MASK = CNT_W'((1 << LOG2) - 1);

  logic [CNT_W-1:0] cons;
  logic             dec;

  assign fill  = prod - cons;
  assign space = MASK - fill;
  assign full  = (fill == MASK);
  assign dec   = dec_req && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod <= '0;
      cons <= '0;
    end else begin
      if (inc) prod <= prod + 1'b1;
      if (dec) cons <= cons + 1'b1;
    end
  end
endmodule

// File: rtl/trb_entry_fmt.sv
module trb_entry_fmt
  import trb_ring_pkg::*;
#(
  parameter int REM_W = 8
) (
  input  logic [63:0]      param,
  input  logic [31:0]      status,
  input  logic [31:0]      ctrl,
  input  logic [REM_W-1:0] remain,
  input  logic             cyc,
  output trb_t             blk
);
  logic [TDSZ_W-1:0] tdsz;

  always_comb begin
    tdsz = (remain > REM_W'(15)) ? TDSZ_W'(15) : TDSZ_W'(remain);
    blk.param  = param;
    blk.status = status;
    blk.status[TDSZ_LSB +: TDSZ_W] = tdsz;
    blk.ctrl   = ctrl;
    blk.ctrl[FLAG_CYCLE] = cyc;
  end
endmodule

// File: rtl/trb_link_fmt.sv
module trb_link_fmt
  import trb_ring_pkg::*;
#(
  parameter logic [63:0] LINK_PTR = 64'h0
) (
  input  logic cyc,
  output trb_t blk
);
  always_comb begin
    blk = '0;
    blk.param = LINK_PTR;
    blk.ctrl[TYPE_LSB +: 6] = TYPE_LINK;
    blk.ctrl[FLAG_TOGGLE]   = 1'b1;
    blk.ctrl[FLAG_CYCLE]    = cyc;
  end
endmodule

// File: rtl/trb_ring_producer.sv
module trb_ring_producer
  import trb_ring_pkg::*;
#(
  parameter int          LOG2     = 3,
  parameter int          CNT_W    = 8,
  parameter int          REM_W    = 8,
  parameter logic [63:0] LINK_PTR = 64'h0000_0000_0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [63:0]       enq_param,
  input  logic [31:0]       enq_status,
  input  logic [31:0]       enq_ctrl,
  input  logic [REM_W-1:0]  enq_remain,
  input  logic [15:0]       enq_target,
  input  logic [15:0]       enq_stream,
  output logic              enq_err,
  input  logic              cons_adv,
  output logic              mem_we,
  output logic [LOG2:0]     mem_addr,
  output logic [127:0]      mem_data,
  output logic [CNT_W-1:0]  fill,
  output logic [CNT_W-1:0]  space,
  output logic              full,
  output logic              db_we,
  output logic [31:0]       db_value
);
  localparam logic [LOG2:0]   LINK_IDX = (LOG2+1)'(1 << LOG2);
  localparam logic [LOG2-1:0] LAST_IDX = {LOG2{1'b1}};

  phase_t           phase;
  logic             cyc;
  logic             accept, take, rej;
  logic [CNT_W-1:0] prod;
  logic [LOG2-1:0]  idx;
  trb_t             data_blk, link_blk;

  assign enq_ready = (phase == PH_RUN);
  assign accept    = enq_valid && enq_ready;
  assign take      = accept && !full;
  assign rej       = accept && full;
  assign idx       = prod[LOG2-1:0];

  trb_ring_ctr #(.LOG2(LOG2), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(take), .dec_req(cons_adv),
    .prod(prod), .fill(fill), .space(space), .full(full)
  );

  trb_entry_fmt #(.REM_W(REM_W)) u_fmt (
    .param(enq_param), .status(enq_status), .ctrl(enq_ctrl),
    .remain(enq_remain), .cyc(cyc), .blk(data_blk)
  );

  // At init the link block is not yet owned by the consumer: cycle bit = ~cyc.
  trb_link_fmt #(.LINK_PTR(LINK_PTR)) u_link (
    .cyc((phase == PH_INIT) ? ~cyc : cyc), .blk(link_blk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_INIT;
      cyc      <= 1'b1;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      db_we    <= 1'b0;
      db_value <= '0;
      enq_err  <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      db_we   <= 1'b0;
      enq_err <= 1'b0;
      unique case (phase)
        PH_INIT: begin
          mem_we   <= 1'b1;
          mem_addr <= LINK_IDX;
          mem_data <= link_blk;
          phase    <= PH_RUN;
        end
        PH_LINK: begin
          mem_we   <= 1'b1;
          mem_addr <= LINK_IDX;
          mem_data <= link_blk;
          cyc      <= ~cyc;
          phase    <= PH_RUN;
        end
        default: begin
          if (take) begin
            mem_we   <= 1'b1;
            mem_addr <= {1'b0, idx};
            mem_data <= data_blk;
            db_we    <= 1'b1;
            db_value <= {enq_stream, enq_target};
            if (idx == LAST_IDX) phase <= PH_LINK;
          end
          if (rej) enq_err <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/trb_ring_producer_chk.sv
module trb_ring_producer_chk #(
  parameter int LOG2  = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_ready,
  input logic             enq_err,
  input logic             mem_we,
  input logic [LOG2:0]    mem_addr,
  input logic [127:0]     mem_data,
  input logic [CNT_W-1:0] fill,
  input logic             db_we
);
  localparam logic [CNT_W-1:0] MASK     = CNT_W'((1 << LOG2) - 1);
  localparam logic [LOG2:0]    LINK_IDX = (LOG2+1)'(1 << LOG2);
  localparam logic [LOG2:0]    LAST_IDX = (LOG2+1)'((1 << LOG2) - 1);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= MASK);

  assert_step_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (fill == $past(fill) || fill == $past(fill) + 1'b1 || fill == $past(fill) - 1'b1));

  assert_reject_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enq_err |-> (!mem_we && !db_we));

  assert_link_format_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == LINK_IDX) |-> (mem_data[111:106] == 6'd6 && mem_data[97] && !db_we));

  assert_link_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == LAST_IDX) |-> !enq_ready);

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr <= LINK_IDX);
endmodule

bind trb_ring_producer trb_ring_producer_chk #(.LOG2(LOG2), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready), .enq_err(enq_err),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
  .fill(fill), .db_we(db_we)
);

// File: tb/test_trb_ring_producer.sv
module test_trb_ring_producer;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2  = 3;
  localparam int CNT_W = 8;
  localparam int REM_W = 8;
  localparam int MASK  = (1 << LOG2) - 1;
  localparam int LINK  = 1 << LOG2;
  localparam logic [63:0] PTR = 64'h0000_0000_0001_0000;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, cons_adv = 0;
  logic [63:0] enq_param = 0;
  logic [31:0] enq_status = 0, enq_ctrl = 0;
  logic [REM_W-1:0] enq_remain = 0;
  logic [15:0] enq_target = 0, enq_stream = 0;
  logic enq_ready, enq_err, mem_we, full, db_we;
  logic [LOG2:0] mem_addr;
  logic [127:0] mem_data;
  logic [CNT_W-1:0] fill, space;
  logic [31:0] db_value;

  int errors = 0, checks = 0;
  int e_prod = 0, e_cons = 0;
  bit e_cyc = 1;
  logic [127:0] mem [0:LINK];

  trb_ring_producer #(.LOG2(LOG2), .CNT_W(CNT_W), .REM_W(REM_W), .LINK_PTR(PTR)) i_trb_ring_producer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (mem_we) mem[mem_addr] = mem_data;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk_counts(input string req);
    int f = (e_prod - e_cons) & ((1 << CNT_W) - 1);
    chk(fill == CNT_W'(f), req, fill, f);
    chk(space == CNT_W'(MASK - f), req, space, MASK - f);
    chk(full == (f == MASK), req, full, f == MASK);
  endtask

  // Single enqueue attempt with optional concurrent consumer advance.
  task automatic enq(input logic [63:0] p, input logic [31:0] s, input logic [31:0] c,
                     input int rem, input logic [15:0] tg, input logic [15:0] st, input bit cadv);
    int f0 = e_prod - e_cons;
    logic [31:0] es, ec;
    int sat = (rem > 15) ? 15 : rem;
    int ix = e_prod & MASK;
    chk(enq_ready, "R9 ready before enqueue", enq_ready, 1);
    enq_valid = 1; enq_param = p; enq_status = s; enq_ctrl = c;
    enq_remain = REM_W'(rem); enq_target = tg; enq_stream = st; cons_adv = cadv;
    tick();
    enq_valid = 0; cons_adv = 0;
    if (f0 == MASK) begin
      chk(enq_err && !mem_we && !db_we, "R6 reject while full", {enq_err, mem_we, db_we}, 3'b100);
    end else begin
      es = (s & ~(32'h1f << 17)) | (32'(sat) << 17);
      ec = (c & ~32'h1) | 32'(e_cyc);
      chk(mem_we && mem_addr == (LOG2+1)'(ix), "R3 write index", mem_addr, ix);
      chk(mem_data == {ec, es, p}, "R3 R4 block layout", mem_data, {ec, es, p});
      chk(db_we && db_value == {st, tg}, "R5 doorbell", db_value, {st, tg});
      chk(!enq_err, "R6 no error when space", enq_err, 0);
      e_prod++;
    end
    if (cadv && f0 > 0) e_cons++;
    chk_counts(cadv ? "R8 counts after concurrent" : "R2 counts");
    if (f0 != MASK && ix == MASK) begin
      chk(!enq_ready, "R9 ready low during link write", enq_ready, 0);
      tick();
      chk(mem_we && mem_addr == (LOG2+1)'(LINK), "R9 link written", mem_addr, LINK);
      chk(mem[LINK][96] == e_cyc && mem[LINK][97], "R9 link cycle", mem[LINK][97:96], {1'b1, e_cyc});
      e_cyc = ~e_cyc;
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    chk(!enq_ready, "R1 ready low in init cycle", enq_ready, 0);
    tick();
    chk(mem_we && mem_addr == (LOG2+1)'(LINK), "R1 link init write", mem_addr, LINK);
    chk(mem[LINK][63:0] == PTR, "R1 link pointer", mem[LINK][63:0], PTR);
    chk(mem[LINK][111:106] == 6'd6 && mem[LINK][97:96] == 2'b10, "R1 link type and flags",
        mem[LINK][111:96], 16'h1802);
    chk(enq_ready, "R1 ready after init", enq_ready, 1);
    chk_counts("R1 counts zero");
  endtask

  task automatic t_empty_adv();
    cons_adv = 1; tick(); cons_adv = 0;
    chk_counts("R7 advance on empty ignored");
  endtask

  task automatic t_basic();
    // normal type (1<<10), interrupt-on-completion (bit5), cycle bit given as 0
    enq(64'hDEAD_BEEF_0000_1000, 32'h0000_0040, 32'h0000_0420, 20, 16'h0003, 16'h0005, 0);
    enq(64'h1111_2222_3333_4444, 32'hFFFF_FFFF, 32'h0000_0451, 5, 16'h0001, 16'hABCD, 0);
  endtask

  task automatic t_fill_full();
    for (int k = 0; k < 5; k++)
      enq(64'(k) << 8, 32'(k), 32'h0000_2010, k, 16'(k), 16'h0, 0);
    chk(full, "R2 full at capacity", full, 1);
    enq(64'h5, 32'h0, 32'h400, 1, 16'h1, 16'h0, 0);
  endtask

  task automatic t_concurrent();
    enq(64'h77, 32'h0, 32'h400, 1, 16'h2, 16'h0, 1);
    enq(64'h88, 32'h0, 32'h440, 2, 16'h2, 16'h1, 1);
  endtask

  task automatic t_after_wrap();
    cons_adv = 1; tick(); cons_adv = 0; e_cons++;
    chk_counts("R7 advance non-empty");
    enq(64'hCAFE, 32'h0, 32'h0000_0421, 3, 16'h9, 16'h0, 0);
    chk(mem[0][96] == e_cyc && e_cyc == 1'b0, "R9 new cycle on wrapped entry", mem[0][96], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_empty_adv();
    t_basic();
    t_fill_full();
    t_concurrent();
    t_after_wrap();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule